// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide register bus. Each pin has two control bytes. The output-control byte sets the pin's direction, its drive style and the level it drives. The input-control byte returns the pin's synchronized level and selects which transitions on the pin raise an interrupt.

Detected edges set sticky status bits. The status and mask bits are split into two groups of unequal size: pins 0 to 6 form the first group and pins 7 to 12 form the second. Software clears a status bit by writing 1 to it. The block raises a single level interrupt while any status bit is set and its mask bit is clear. An interrupt handler therefore re-reads both status bytes and keeps servicing until both read zero.

On the pad side, each pin has an input, an output value and an output enable. Open-drain mode is emulated by enabling the driver only when the pin is to be pulled low. The bits that select a pull resistor are stored and read back, but they drive nothing.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pad output enable is 0, the interrupt output is 0, both status bytes (0x4E0B, 0x4E0C) read 0x00, the mask bytes read 0x7F (0x4E19) and 0x3F (0x4E1A), and every output-control byte reads 0x00.
- R2: The output-control byte of pin i is at address 0x4E44+i. Bits 5:0 are stored and read back: bit 5 is direction (1 = output), bit 4 is drive (1 = push-pull, 0 = open-drain), bit 3 is pull enable and bits 2:1 are the pull choice. Bit 0 is the output value. Bits 7:6 read 0.
- R3: A pin that is an output in push-pull mode has its output enable at 1, and its pad output equals bit 0 of its output-control byte.
- R4: A pin that is an output in open-drain mode drives its pad output at 0. Its output enable is 1 when bit 0 is 0 and 0 when bit 0 is 1. An input pin never has its output enable set.
- R5: The input-control byte of pin i is at address 0x4E51+i. Bit 0 reads the pin level after a two-flop synchronizer. Bits 2:1 read back the edge select. Bits 7:3 read 0.
- R6: The edge-select codes are 00 = no detection, 01 = falling edge, 10 = rising edge and 11 = both edges. A transition that matches the code sets the pin's status bit.
- R7: Pins 0 to 6 map to bits 0 to 6 of the status byte 0x4E0B and the mask byte 0x4E19. Pins 7 to 12 map to bits 0 to 5 of the status byte 0x4E0C and the mask byte 0x4E1A.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status bit that is not cleared stays set.
- R9: A matching edge sets the status bit even while the pin's mask bit is 1.
- R10: The interrupt output is 1 exactly when some status bit is 1 and its mask bit (1 = blocked) is 0.
- R11: Reads of unmapped addresses return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read strobe; read data is registered on the same edge |
| bus_rdata | output | 8 | Read data, holds until the next read |
| pad_in | input | 13 | Pin levels from the pads |
| pad_out | output | 13 | Values driven to the pads |
| pad_oe | output | 13 | Pad output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the edge-select codes one at a time.
- A design that decodes a code wrongly would set status on the wrong transition, for example on a fall with rising-only selected.
- A design that treats code 00 as active would flag a pin whose detection is disabled.

The group boundary is tested with pins 7 and 10.
- If pin 7 were not mapped to bit 0 of the second group, its status would show up in the first group's byte.

The write-one-to-clear rule is tested in both directions.
- A design that cleared on any write would lose the pending bit when 0x00 is written.

A status bit is set while masked, and the interrupt is then checked as the mask is opened.
- A design that gated status with the mask would never raise the interrupt after unmasking.

In open-drain mode the output enable is checked for both output values.
- A design that drove high in open-drain mode would show the enable and the output both at 1.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int NPINS    = 13;
  localparam int G0_PINS  = 7;
  localparam int G1_PINS  = NPINS - G0_PINS;
  localparam int AW       = 16;
  localparam int DW       = 8;
  localparam int SYNC_STG = 2;

  localparam logic [AW-1:0] OCTL_BASE = 16'h4E44;
  localparam logic [AW-1:0] ICTL_BASE = 16'h4E51;
  localparam logic [AW-1:0] STAT_BASE = 16'h4E0B;
  localparam logic [AW-1:0] MASK_BASE = 16'h4E19;

  // output-control byte fields
  localparam int OC_DIR = 5;
  localparam int OC_PP  = 4;
  localparam int OC_VAL = 0;
  localparam int OC_W   = 6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_edge_pkg::*;
#(
  parameter int STAGES = SYNC_STG
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pad_i,
  input  edge_sel_e sel,
  output logic      level,
  output logic      evt
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;
  logic              rise, fall;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pad_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_FALL: evt = fall;
      EDGE_RISE: evt = rise;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  // R6: detection disabled never flags
  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_OFF) |-> !evt);
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         stat_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] stat_d, mask_d, clr;

  always_comb begin
    clr    = stat_we ? wdata : '0;
    // a new edge wins over a clear in the same cycle
    stat_d = (status & ~clr) | evt;
    mask_d = mask_we ? wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= stat_d;
      if (mask_we) mask <= mask_d;
    end
  end

  assign irq = |(status & ~mask);

  // R8: a status bit only falls through a clearing write
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> (($past(status) & ~status) == '0));
  // R9: an event sets status regardless of mask
  a_r9_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));
  // R10: fully masked group stays quiet
  a_r10_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [NPINS-1:0][OC_W-1:0] octl_q, octl_d;
  edge_sel_e [NPINS-1:0]      esel_q, esel_d;
  logic [NPINS-1:0]           hit_o, hit_i, level, evt;
  logic [NPINS-1:0]           dir_v, pp_v, val_v;
  logic [DW-1:0]              rd_d, rdata_q;
  logic                       unused_wbit;

  assign unused_wbit = bus_wdata[7];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit_o[i] = (bus_addr == OCTL_BASE + AW'(i));
    assign hit_i[i] = (bus_addr == ICTL_BASE + AW'(i));
    assign dir_v[i] = octl_q[i][OC_DIR];
    assign pp_v[i]  = octl_q[i][OC_PP];
    assign val_v[i] = octl_q[i][OC_VAL];
    assign pad_oe[i]  = dir_v[i] & (pp_v[i] | ~val_v[i]);
    assign pad_out[i] = val_v[i] & pp_v[i];

    gpio_pin_sense #(.STAGES(SYNC_STG)) u_sense (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pad_i (pad_in[i]),
      .sel   (esel_q[i]),
      .level (level[i]),
      .evt   (evt[i])
    );
  end

  always_comb begin
    octl_d = octl_q;
    esel_d = esel_q;
    for (int i = 0; i < NPINS; i++) begin
      if (bus_we && hit_o[i]) octl_d[i] = bus_wdata[OC_W-1:0];
      if (bus_we && hit_i[i]) esel_d[i] = edge_sel_e'(bus_wdata[2:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      octl_q <= '0;
      esel_q <= {NPINS{EDGE_OFF}};
    end else begin
      octl_q <= octl_d;
      esel_q <= esel_d;
    end
  end

  // interrupt groups
  logic          st0_we, st1_we, mk0_we, mk1_we, irq0, irq1;
  logic [G0_PINS-1:0] stat0, mask0;
  logic [G1_PINS-1:0] stat1, mask1;

  assign st0_we = bus_we && (bus_addr == STAT_BASE);
  assign st1_we = bus_we && (bus_addr == STAT_BASE + AW'(1));
  assign mk0_we = bus_we && (bus_addr == MASK_BASE);
  assign mk1_we = bus_we && (bus_addr == MASK_BASE + AW'(1));

  gpio_irq_group #(.W(G0_PINS)) u_grp0 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt     (evt[G0_PINS-1:0]),
    .stat_we (st0_we),
    .mask_we (mk0_we),
    .wdata   (bus_wdata[G0_PINS-1:0]),
    .status  (stat0),
    .mask    (mask0),
    .irq     (irq0)
  );

  gpio_irq_group #(.W(G1_PINS)) u_grp1 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt     (evt[NPINS-1:G0_PINS]),
    .stat_we (st1_we),
    .mask_we (mk1_we),
    .wdata   (bus_wdata[G1_PINS-1:0]),
    .status  (stat1),
    .mask    (mask1),
    .irq     (irq1)
  );

  assign irq = irq0 | irq1;

  // read mux
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (hit_o[i]) rd_d = DW'(octl_q[i]);
      if (hit_i[i]) rd_d = DW'({esel_q[i], level[i]});
    end
    if (bus_addr == STAT_BASE)          rd_d = DW'(stat0);
    if (bus_addr == STAT_BASE + AW'(1)) rd_d = DW'(stat1);
    if (bus_addr == MASK_BASE)          rd_d = DW'(mask0);
    if (bus_addr == MASK_BASE + AW'(1)) rd_d = DW'(mask1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_re)  rdata_q <= rd_d;
  end
  assign bus_rdata = rdata_q;

  // R4: an input pin is never driven
  a_r4_input_undriven: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & ~dir_v) == '0);
  // R4: open-drain never drives high
  a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & pad_out & ~pp_v) == '0);
  // R3: push-pull output always enabled
  a_r3_pp_enabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((dir_v & pp_v) & ~pad_oe) == '0);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [12:0] pad_in = '0;
  logic [12:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {write, addr, wdata, expected}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h4E50, 8'hFF, 8'h00},
    {1'b0, 16'h4E50, 8'h00, 8'h3F},
    {1'b1, 16'h4E44, 8'h2A, 8'h00},
    {1'b0, 16'h4E44, 8'h00, 8'h2A},
    {1'b1, 16'h4E52, 8'hFF, 8'h00},
    {1'b0, 16'h4E52, 8'h00, 8'h06},
    {1'b0, 16'h4E43, 8'h00, 8'h00},
    {1'b0, 16'h4E5E, 8'h00, 8'h00},
    {1'b1, 16'h4E30, 8'h55, 8'h00},
    {1'b0, 16'h4E30, 8'h00, 8'h00},
    {1'b0, 16'h4E0D, 8'h00, 8'h00},
    {1'b0, 16'h4E1B, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(tag, 32'(d), 32'(exp));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    read_chk("R1 mask0", 16'h4E19, 8'h7F);
    read_chk("R1 mask1", 16'h4E1A, 8'h3F);
    read_chk("R1 stat0", 16'h4E0B, 8'h00);
    read_chk("R1 stat1", 16'h4E0C, 8'h00);
    read_chk("R1 octl", 16'h4E48, 8'h00);

    // table: R2 readback, R5 edge-select readback, R11 unmapped
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][32]) bus_write(VEC[k][31:16], VEC[k][15:8]);
      else read_chk($sformatf("R2 R5 R11 table entry %0d", k), VEC[k][31:16], VEC[k][7:0]);
    end

    // R3 push-pull on pin 2
    bus_write(16'h4E46, 8'h31);
    check("R3 pp oe", 32'(pad_oe[2]), 32'h1);
    check("R3 pp out high", 32'(pad_out[2]), 32'h1);
    bus_write(16'h4E46, 8'h30);
    check("R3 pp out low", 32'(pad_out[2]), 32'h0);

    // R4 open-drain on pin 4
    bus_write(16'h4E48, 8'h20);
    check("R4 od low oe", 32'(pad_oe[4]), 32'h1);
    check("R4 od low out", 32'(pad_out[4]), 32'h0);
    bus_write(16'h4E48, 8'h21);
    check("R4 od high released", 32'(pad_oe[4]), 32'h0);
    bus_write(16'h4E48, 8'h11);
    check("R4 input undriven", 32'(pad_oe[4]), 32'h0);

    // R5 level readback on pin 9
    pad_in[9] = 1'b1; settle();
    read_chk("R5 level high", 16'h4E5A, 8'h01);
    read_chk("R6 no status with detection off", 16'h4E0C, 8'h00);

    // R6 rise on pin 3, R9 masked set, R10 gating
    bus_write(16'h4E54, 8'h04);
    pad_in[3] = 1'b1; settle();
    read_chk("R6 R9 rise pin3", 16'h4E0B, 8'h08);
    check("R10 masked irq low", 32'(irq), 32'h0);
    bus_write(16'h4E19, 8'h00);
    check("R10 unmasked irq high", 32'(irq), 32'h1);
    bus_write(16'h4E0B, 8'h00);
    read_chk("R8 zero write keeps", 16'h4E0B, 8'h08);
    bus_write(16'h4E0B, 8'h08);
    read_chk("R8 one write clears", 16'h4E0B, 8'h00);
    check("R10 irq low after clear", 32'(irq), 32'h0);
    pad_in[3] = 1'b0; settle();
    read_chk("R6 rise-only ignores fall", 16'h4E0B, 8'h00);

    // R6 fall on pin 10, R7 group 1 bit 3
    bus_write(16'h4E5B, 8'h02);
    pad_in[10] = 1'b1; settle();
    read_chk("R6 fall-only ignores rise", 16'h4E0C, 8'h00);
    pad_in[10] = 1'b0; settle();
    read_chk("R6 R7 fall pin10", 16'h4E0C, 8'h08);
    check("R10 group1 masked", 32'(irq), 32'h0);
    bus_write(16'h4E1A, 8'h37);
    check("R10 group1 unmasked", 32'(irq), 32'h1);
    bus_write(16'h4E0C, 8'h08);
    check("R8 R10 cleared group1", 32'(irq), 32'h0);

    // R6 both edges on pin 9
    bus_write(16'h4E5A, 8'h06);
    read_chk("R5 sel and level", 16'h4E5A, 8'h07);
    pad_in[9] = 1'b0; settle();
    read_chk("R6 both fall", 16'h4E0C, 8'h04);
    bus_write(16'h4E0C, 8'h04);
    pad_in[9] = 1'b1; settle();
    read_chk("R6 both rise", 16'h4E0C, 8'h04);
    bus_write(16'h4E0C, 8'h04);

    // R6 pin 5 detection off
    pad_in[5] = 1'b1; settle();
    pad_in[5] = 1'b0; settle();
    read_chk("R6 off pin5", 16'h4E0B, 8'h00);

    // R7 pin 7 lands in group 1 bit 0
    bus_write(16'h4E58, 8'h04);
    pad_in[7] = 1'b1; settle();
    read_chk("R7 pin7 group1", 16'h4E0C, 8'h01);
    read_chk("R7 pin7 not group0", 16'h4E0B, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule